// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block serialises bytes onto an asynchronous serial line. Software writes a byte into a one-byte holding buffer. The frame sequencer takes that byte into its own shift register as soon as it is free. Because the buffer and the shift register are separate, the next byte can be queued while the current frame is still going out. The frames then follow each other with no idle gap.

Each frame has a low start bit, eight data bits sent least significant bit first, an optional parity bit and a high stop bit. An external single-cycle enable pulse paces the bits: each pulse ends the bit currently on the line.

Software uses a small register window. It holds a status register with a buffer-empty flag and a busy flag, a write-only data register one address above it, and a control register with an enable bit and parity settings. An interrupt request is raised when the buffer empties.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset the line is high (idle), status reads 0x01, control reads 0x00 and the interrupt output is low.
- R2: The register window is as follows. Address 0 is status: bit 0 is buffer-empty, bit 2 is busy and the other bits read 0. Address 1 is the write-only transmit data register and reads 0. Address 2 is control: bit 0 is enable, bit 1 is parity-enable and bit 2 is odd-parity select.
- R3: A frame is a 0 start bit, then data bits 0 to 7, then a 1 stop bit. The line holds each bit until a bit_tick pulse ends it. The start bit appears one clock after the byte is written into an empty buffer while the transmitter is idle.
- R4: With parity enabled, one parity bit follows data bit 7. With even parity, this bit is the XOR of the data. With odd parity, it is the inverse of that XOR.
- R5: Buffer-empty reads 0 in the cycle after a data write. It reads 1 again from the clock edge on which the byte moves into the shift register.
- R6: Busy reads 1 from the load of the shift register until the tick that ends the stop bit. On that tick it falls, unless another byte is loaded on the same edge.
- R7: A data write while the buffer already holds a byte replaces that byte. The replaced byte is never sent, and no error indication exists.
- R8: A byte that is pending when the stop-bit tick arrives is loaded on that same edge. The next start bit follows immediately, and busy stays 1.
- R9: The interrupt request goes high on the edge on which the buffer hands its byte to the shift register. It stays high until status is read (reg_rd at address 0) or the data register is written. If a hand-off and a status read fall in the same cycle, the request is set.
- R10: While enable is 0, the line is high, buffer-empty reads 1, busy reads 0 and the interrupt request is low. Data writes are ignored. Clearing enable abandons the frame in progress and any pending byte.
- R11: While enable is 1, a control write changes only the enable bit. The parity settings keep their values.
- R12: If a data write falls on the same edge as a hand-off, the old byte goes to the shift register and the new byte stays pending. Buffer-empty stays 0 and no interrupt request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| bit_tick | input | 1 | Single-cycle pulse that ends the current serial bit |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; used to acknowledge the interrupt |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| txd | output | 1 | Serial output, idle high |
| tx_irq | output | 1 | Buffer-empty interrupt request |

## Verification
Two events can land on the same clock edge: a software write to the data register and the buffer's hand-off to the shift register. The bench provokes this by writing a first byte into an idle transmitter and writing a second byte in the very next cycle, which is the cycle of the hand-off. It then judges the outcome at the ports. Busy must be 1, buffer-empty must stay 0 and the interrupt request must stay low. Both frames must then go out back to back, in order and with the correct bits. A second pairing is also checked: a hand-off at the stop-bit tick together with a pending byte, where busy must not drop.

// File: rtl/utx_pkg.sv
package utx_pkg;

  localparam int REG_AW = 2;

  localparam logic [REG_AW-1:0] ADDR_STATUS  = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_TXDATA  = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_CONTROL = 2'd2;

  localparam int ST_EMPTY_BIT = 0;
  localparam int ST_BUSY_BIT  = 2;
  localparam int CT_EN_BIT    = 0;
  localparam int CT_PAREN_BIT = 1;
  localparam int CT_ODD_BIT   = 2;
  localparam int CT_FIELDS    = 3;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_PARITY,
    TX_STOP
  } tx_state_e;

  typedef struct packed {
    logic odd;
    logic par_en;
    logic en;
  } tx_cfg_t;

endpackage

// File: rtl/utx_regs.sv
module utx_regs
  import utx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [CT_FIELDS-1:0] ctrl_wdata,
  input  logic                 buf_empty,
  input  logic                 tx_busy,
  output tx_cfg_t              cfg,
  output logic                 wr_txdata,
  output logic                 rd_status,
  output logic [DATA_W-1:0]    reg_rdata
);

  tx_cfg_t cfg_q, cfg_d;
  logic    wr_ctrl;

  assign wr_ctrl   = reg_wr && (reg_addr == ADDR_CONTROL);
  assign wr_txdata = reg_wr && (reg_addr == ADDR_TXDATA);
  assign rd_status = reg_rd && (reg_addr == ADDR_STATUS);

  // Parity settings are frozen while the transmitter is enabled
  always_comb begin
    cfg_d = cfg_q;
    if (wr_ctrl) begin
      cfg_d.en = ctrl_wdata[CT_EN_BIT];
      if (!cfg_q.en) begin
        cfg_d.par_en = ctrl_wdata[CT_PAREN_BIT];
        cfg_d.odd    = ctrl_wdata[CT_ODD_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_ctrl) begin
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_STATUS: begin
        reg_rdata[ST_EMPTY_BIT] = buf_empty;
        reg_rdata[ST_BUSY_BIT]  = tx_busy;
      end
      ADDR_CONTROL: begin
        reg_rdata[CT_EN_BIT]    = cfg_q.en;
        reg_rdata[CT_PAREN_BIT] = cfg_q.par_en;
        reg_rdata[CT_ODD_BIT]   = cfg_q.odd;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign cfg = cfg_q;

  assert_cfg_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_q.en) && cfg_q.en) |-> ($stable(cfg_q.par_en) && $stable(cfg_q.odd)));

endmodule

// File: rtl/utx_holdbuf.sv
module utx_holdbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_status,
  input  logic              shift_ready,
  output logic              load,
  output logic [DATA_W-1:0] load_data,
  output logic              empty,
  output logic              irq
);

  logic              full_q, full_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              irq_q, irq_d;
  logic              wr_ok;

  assign wr_ok = en && wr;
  assign load  = en && full_q && shift_ready;

  always_comb begin
    full_d = full_q;
    buf_d  = buf_q;
    irq_d  = irq_q;
    if (!en) begin
      full_d = 1'b0;
      irq_d  = 1'b0;
    end else begin
      if (load) full_d = 1'b0;
      if (wr_ok) begin
        full_d = 1'b1;
        buf_d  = wdata;
      end
      if (rd_status || wr_ok) irq_d = 1'b0;
      if (load && !wr_ok)     irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      irq_q  <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (wr_ok) begin
      buf_q <= buf_d;
    end
  end

  assign load_data = buf_q;
  assign empty     = !full_q || !en;
  assign irq       = irq_q;

  assert_write_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr) |=> full_q);

  assert_irq_on_handoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $fell(full_q)) |-> irq_q);

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
  import utx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              par_en,
  input  logic              odd,
  output logic              ready,
  output logic              busy_o,
  output logic              txd_o
);

  localparam int              CNT_W    = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  tx_state_e         state_q, state_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              par_bit_q, par_bit_d;
  logic              par_use_q, par_use_d;

  assign ready = en && ((state_q == TX_IDLE) || ((state_q == TX_STOP) && tick));

  always_comb begin
    state_d   = state_q;
    shreg_d   = shreg_q;
    cnt_d     = cnt_q;
    par_bit_d = par_bit_q;
    par_use_d = par_use_q;
    if (!en) begin
      state_d = TX_IDLE;
    end else begin
      unique case (state_q)
        TX_IDLE: ;
        TX_START: if (tick) begin
          state_d = TX_DATA;
          cnt_d   = '0;
        end
        TX_DATA: if (tick) begin
          shreg_d = shreg_q >> 1;
          if (cnt_q == LAST_BIT) state_d = par_use_q ? TX_PARITY : TX_STOP;
          else                   cnt_d   = cnt_q + 1'b1;
        end
        TX_PARITY: if (tick) state_d = TX_STOP;
        TX_STOP:   if (tick) state_d = TX_IDLE;
        default:   state_d = TX_IDLE;
      endcase
      if (load) begin
        state_d   = TX_START;
        shreg_d   = load_data;
        par_bit_d = (^load_data) ^ odd;
        par_use_d = par_en;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= TX_IDLE;
      shreg_q   <= '0;
      cnt_q     <= '0;
      par_bit_q <= 1'b0;
      par_use_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      shreg_q   <= shreg_d;
      cnt_q     <= cnt_d;
      par_bit_q <= par_bit_d;
      par_use_q <= par_use_d;
    end
  end

  always_comb begin
    txd_o = 1'b1;
    if (en) begin
      unique case (state_q)
        TX_START:  txd_o = 1'b0;
        TX_DATA:   txd_o = shreg_q[0];
        TX_PARITY: txd_o = par_bit_q;
        default:   txd_o = 1'b1;
      endcase
    end
  end

  assign busy_o = en && (state_q != TX_IDLE);

  assert_busy_ends_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $fell(busy_o)) |-> $past(tick));

  assert_bit_held_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(busy_o) && !$past(tick)) |-> $stable(txd_o));

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import utx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              txd,
  output logic              tx_irq
);

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[RST_STAGES-1];

  tx_cfg_t           cfg;
  logic              wr_txdata, rd_status;
  logic              buf_empty, tx_busy, shift_ready, load;
  logic [DATA_W-1:0] load_data;

  utx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .ctrl_wdata (reg_wdata[CT_FIELDS-1:0]),
    .buf_empty  (buf_empty),
    .tx_busy    (tx_busy),
    .cfg        (cfg),
    .wr_txdata  (wr_txdata),
    .rd_status  (rd_status),
    .reg_rdata  (reg_rdata)
  );

  utx_holdbuf #(.DATA_W(DATA_W)) u_holdbuf (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .en          (cfg.en),
    .wr          (wr_txdata),
    .wdata       (reg_wdata),
    .rd_status   (rd_status),
    .shift_ready (shift_ready),
    .load        (load),
    .load_data   (load_data),
    .empty       (buf_empty),
    .irq         (tx_irq)
  );

  utx_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (cfg.en),
    .tick      (bit_tick),
    .load      (load),
    .load_data (load_data),
    .par_en    (cfg.par_en),
    .odd       (cfg.odd),
    .ready     (shift_ready),
    .busy_o    (tx_busy),
    .txd_o     (txd)
  );

  assert_disabled_idle_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg.en |-> (txd && !tx_busy && buf_empty));

endmodule

// File: tb/uart_tx_dbuf_test.sv
`timescale 1ns/1ps
module uart_tx_dbuf_test;

  logic       clk, rst_n, bit_tick, reg_wr, reg_rd, txd, tx_irq;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  int         n_chk, n_bad;
  bit         done;

  uart_tx_dbuf uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .txd(txd), .tx_irq(tx_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {parity enable, odd select, data}
  localparam logic [9:0] VEC [0:5] = '{
    {1'b0, 1'b0, 8'hA5}, {1'b0, 1'b0, 8'h01}, {1'b1, 1'b0, 8'h3C},
    {1'b1, 1'b0, 8'h07}, {1'b1, 1'b1, 8'hF0}, {1'b1, 1'b1, 8'h80}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic rd_status(output logic [7:0] v);
    reg_addr = 2'd0; reg_rd = 1'b1; #1; v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic tick();
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  // Called with the start bit on the line; ends right after the stop-bit tick
  task automatic check_frame(input logic [7:0] d, input bit pe, input bit odd,
                             input string req);
    logic exp [0:10];
    int   n, bad_i;
    n = pe ? 11 : 10;
    exp[0] = 1'b0;
    for (int k = 0; k < 8; k++) exp[k+1] = d[k];
    if (pe) exp[9] = (^d) ^ odd;
    exp[n-1] = 1'b1;
    bad_i = -1;
    for (int i = 0; i < n; i++) begin
      if (txd !== exp[i] && bad_i < 0) bad_i = i;
      tick();
    end
    check(bad_i < 0, req, $sformatf("frame %02h bit %0d", d, bad_i),
          (bad_i < 0) ? 0 : int'(txd), (bad_i < 0) ? 0 : int'(exp[bad_i]));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; bit_tick = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_addr = 2'd0; reg_wdata = 8'h00;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R1 reset state
    check(txd === 1'b1, "R1", "txd", int'(txd), 1);
    check(tx_irq === 1'b0, "R1", "irq", int'(tx_irq), 0);
    peek(2'd0, v); check(v === 8'h01, "R1", "status", int'(v), 1);
    peek(2'd2, v); check(v === 8'h00, "R1", "control", int'(v), 0);

    // R2 register window
    wr(2'd2, 8'hFE);
    peek(2'd2, v); check(v === 8'h06, "R2", "control readback", int'(v), 6);
    peek(2'd1, v); check(v === 8'h00, "R2", "data reg reads 0", int'(v), 0);
    peek(2'd0, v); check(v === 8'h01, "R2", "status disabled", int'(v), 1);

    // Vector walk: R3 R4 R5 R6 R9
    for (int i = 0; i < 6; i++) begin
      logic [7:0] d;
      bit pe, od;
      d = VEC[i][7:0]; pe = VEC[i][9]; od = VEC[i][8];
      wr(2'd2, 8'h00);
      wr(2'd2, {5'b0, od, pe, 1'b0});
      wr(2'd2, {5'b0, od, pe, 1'b1});
      wr(2'd1, d);
      peek(2'd0, v); check(v === 8'h00, "R5", "empty low after write", int'(v), 0);
      cyc(1);
      peek(2'd0, v); check(v === 8'h05, "R6", "busy and empty after load", int'(v), 5);
      check(tx_irq === 1'b1, "R9", "irq on hand-off", int'(tx_irq), 1);
      check_frame(d, pe, od, pe ? "R4" : "R3");
      peek(2'd0, v); check(v === 8'h01, "R6", "busy low after stop", int'(v), 1);
      check(tx_irq === 1'b1, "R9", "irq held", int'(tx_irq), 1);
      rd_status(v);
      check(tx_irq === 1'b0, "R9", "irq cleared by status read", int'(tx_irq), 0);
    end

    // R8 back to back, irq cleared by data write
    wr(2'd2, 8'h00); wr(2'd2, 8'h01);
    wr(2'd1, 8'h5A); cyc(1);
    wr(2'd1, 8'hC3);
    check(tx_irq === 1'b0, "R9", "irq cleared by data write", int'(tx_irq), 0);
    check_frame(8'h5A, 1'b0, 1'b0, "R8");
    check(txd === 1'b0, "R8", "next start bit at once", int'(txd), 0);
    peek(2'd0, v); check(v === 8'h05, "R8", "busy kept, buffer empty", int'(v), 5);
    check_frame(8'hC3, 1'b0, 1'b0, "R8");
    rd_status(v);

    // R7 overwrite while full
    wr(2'd1, 8'h11); cyc(1);
    wr(2'd1, 8'h22); wr(2'd1, 8'h9E);
    peek(2'd0, v); check(v === 8'h04, "R7", "pending, busy", int'(v), 4);
    check_frame(8'h11, 1'b0, 1'b0, "R7");
    check_frame(8'h9E, 1'b0, 1'b0, "R7");
    peek(2'd0, v); check(v === 8'h01, "R7", "old byte never sent", int'(v), 1);
    rd_status(v);

    // R12 write coinciding with hand-off
    wr(2'd1, 8'h6B);
    wr(2'd1, 8'h94);
    peek(2'd0, v); check(v === 8'h04, "R12", "busy with byte pending", int'(v), 4);
    check(tx_irq === 1'b0, "R12", "no irq", int'(tx_irq), 0);
    check_frame(8'h6B, 1'b0, 1'b0, "R12");
    check_frame(8'h94, 1'b0, 1'b0, "R12");
    rd_status(v);

    // R10 disable mid-frame
    wr(2'd1, 8'h0F); cyc(1);
    tick(); tick(); tick();
    wr(2'd1, 8'hAA);
    wr(2'd2, 8'h00);
    check(txd === 1'b1, "R10", "line idle", int'(txd), 1);
    check(tx_irq === 1'b0, "R10", "irq low", int'(tx_irq), 0);
    peek(2'd0, v); check(v === 8'h01, "R10", "status disabled", int'(v), 1);
    wr(2'd1, 8'h55);
    wr(2'd2, 8'h01);
    cyc(2);
    peek(2'd0, v); check(v === 8'h01, "R10", "nothing sent after re-enable", int'(v), 1);
    check(txd === 1'b1, "R10", "line still idle", int'(txd), 1);

    // R11 parity settings locked while enabled
    wr(2'd2, 8'h07);
    peek(2'd2, v); check(v === 8'h01, "R11", "control locked", int'(v), 1);
    wr(2'd1, 8'h3D); cyc(1);
    check_frame(8'h3D, 1'b0, 1'b0, "R11");
    peek(2'd0, v); check(v === 8'h01, "R11", "frame had no parity bit", int'(v), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule